// File: doc/BRIEF.md
# Paged write protection and erase controller

This block guards a tightly coupled RAM that is split into equal pages. The default is 32 pages of 1 KB, with 256 words of 32 bits in each page. Each page has one protect bit. Software can set a protect bit but cannot clear it, and every protect bit clears on system reset. When a bus write request targets a page whose bit is set, the block withholds the write-allow signal and records a sticky violation flag.

The block also runs a hardware erase. It drives the RAM's write port with zero at every word address in turn, one address per clock, from the lowest address to the highest. Three events start an erase:
- software setting the erase bit of the control register;
- a strobe that reports a readout-protection downgrade from level 1 to level 0;
- reset release, when the reset-erase option input is high.

While the sweep runs, the busy output is high and every bus write is dropped. The sweep ignores the protect bits.

The register port has one select bit. Select 0 is the protect-set register and select 1 is the control register. The RAM array is outside the block.

Top module: `ram_guard`

## Requirements
- R1: After reset (with `rst_erase_opt_i` low), `prot_o` is all zero and `busy_o`, `erase_o`, `viol_o` and `mem_we_o` are 0.
- R2: A register write with select 0 ORs `reg_wdata_i` into the protect bits, where bit p guards page p. A 0 written to a set bit does not clear it, so protect bits never fall until reset.
- R3: The page of a bus address is the word address divided by the page size in words. `bus_allow_o` is 1 exactly when `bus_req_i` is high, the addressed page's protect bit is 0, and no sweep is running. `bus_allow_o` is combinational.
- R4: A bus request that is refused because its page is protected sets `viol_o` at the next clock edge. `viol_o` holds until a register write with select 1 and bit 1 set, which clears it at the next edge.
- R5: A register write with select 1 and bit 0 set, made while idle, starts a sweep. `busy_o` and `erase_o` are 1 from the next clock edge.
- R6: A sweep asserts `mem_we_o` for exactly one cycle per word. It presents addresses 0, 1, ... up to the last word in consecutive cycles, with `mem_wdata_o` equal to zero. Protected pages are covered too, and the protect bits are left unchanged.
- R7: `busy_o` is high for exactly as many cycles as the RAM has words. A software-started `erase_o` falls together with `busy_o`.
- R8: During a sweep, `bus_allow_o` is 0 for any address, and refused requests do not set `viol_o`.
- R9: If `rst_erase_opt_i` is high at reset release, a sweep starts at the first clock edge after reset, and `erase_o` stays 0. If it is low, no sweep starts.
- R10: A one-cycle pulse on `rdp_drop_i` starts a sweep while idle. Any trigger that arrives during a sweep neither extends nor restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = protect-set, 1 = control |
| reg_wdata_i | input | PAGES | Write data (control: bit 0 = erase, bit 1 = clear violation) |
| bus_req_i | input | 1 | Bus write request |
| bus_addr_i | input | ADDR_W | Bus write word address |
| rst_erase_opt_i | input | 1 | Option: erase after reset |
| rdp_drop_i | input | 1 | Readout protection level 1 to 0 strobe |
| bus_allow_o | output | 1 | Bus write may proceed |
| viol_o | output | 1 | Sticky write-violation flag |
| prot_o | output | PAGES | Protect bits, one per page |
| erase_o | output | 1 | Software erase bit; self-clears when the sweep ends |
| busy_o | output | 1 | Sweep in progress |
| mem_we_o | output | 1 | RAM write enable from the sweep |
| mem_addr_o | output | ADDR_W | RAM word address from the sweep |
| mem_wdata_o | output | DATA_W | RAM write data from the sweep (zero) |

## Verification
The bench uses a 4-page, 16-word configuration and probes every word address under three protection masks: none, two separated pages, and three pages.
- The all-clear mask shows that no address is refused by default.
- The two set masks show whether the page index is taken from the right address bits, and whether violations follow exactly the refused requests.

Each erase source is started once:
- the software bit, while a request to a protected page is held;
- the readout-downgrade strobe, with a second strobe in mid-sweep;
- reset with the option bit high.

Counting write-enable cycles and the address order per sweep separates a missed, restarted or extended sweep from a correct one.

// File: rtl/ram_guard_pkg.sv
package ram_guard_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SWEEP = 1'b1} sweep_st_e;
  localparam logic SEL_PROT = 1'b0;
  localparam logic SEL_CTRL = 1'b1;
  localparam int CTRL_ERASE_BIT = 0;
  localparam int CTRL_VCLR_BIT  = 1;
endpackage

// File: rtl/prot_bank.sv
module prot_bank #(
  parameter int PAGES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic [PAGES-1:0] set_mask_i,
  output logic [PAGES-1:0] prot_o
);
  for (genvar p = 0; p < PAGES; p++) begin : g_page
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else if (set_we_i && set_mask_i[p]) bit_q <= 1'b1;
    end
    assign prot_o[p] = bit_q;
  end

  AST_PROT_SET_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(prot_o) & ~prot_o) == '0)); // R2
endmodule

// File: rtl/page_check.sv
module page_check #(
  parameter int PAGES      = 32,
  parameter int PAGE_WORDS = 256,
  parameter int ADDR_W     = 13
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGES-1:0]  prot_i,
  input  logic              busy_i,
  output logic              allow_o,
  output logic              block_o
);
  localparam int OFF_W = $clog2(PAGE_WORDS);
  localparam int PG_W  = ADDR_W - OFF_W;

  logic [PG_W-1:0] page;
  logic            hit;
  logic            unused_off;

  assign page       = addr_i[ADDR_W-1:OFF_W];
  assign unused_off = ^addr_i[OFF_W-1:0];
  assign hit        = prot_i[page];
  assign allow_o    = req_i && !busy_i && !hit;
  assign block_o    = req_i && !busy_i && hit;
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import ram_guard_pkg::*;
#(
  parameter int WORDS  = 8192,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

  sweep_st_e         st_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              at_last;

  assign busy_o  = (st_q == ST_SWEEP);
  assign at_last = (cnt_q == LAST);
  assign done_o  = busy_o && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_SWEEP;
          cnt_q <= '0;
        end
        ST_SWEEP: begin
          cnt_q <= cnt_q + 1'b1;
          if (at_last) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_we_o    = busy_o;
  assign mem_addr_o  = cnt_q;
  assign mem_wdata_o = '0;

  AST_SWEEP_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mem_addr_o == '0)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R6
  AST_END_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(mem_addr_o) == LAST)); // R7
endmodule

// File: rtl/ram_guard.sv
module ram_guard
  import ram_guard_pkg::*;
#(
  parameter int PAGES      = 32,
  parameter int PAGE_WORDS = 256,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = $clog2(PAGES * PAGE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [PAGES-1:0]  reg_wdata_i,
  input  logic              bus_req_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              rst_erase_opt_i,
  input  logic              rdp_drop_i,
  output logic              bus_allow_o,
  output logic              viol_o,
  output logic [PAGES-1:0]  prot_o,
  output logic              erase_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int WORDS = PAGES * PAGE_WORDS;
  localparam int OFF_W = $clog2(PAGE_WORDS);

  logic prot_we, sw_erase, vclr, block, start, done;
  logic boot_pend_q, erase_q, viol_q;

  assign prot_we  = reg_we_i && (reg_sel_i == SEL_PROT);
  assign sw_erase = reg_we_i && (reg_sel_i == SEL_CTRL) && reg_wdata_i[CTRL_ERASE_BIT];
  assign vclr     = reg_we_i && (reg_sel_i == SEL_CTRL) && reg_wdata_i[CTRL_VCLR_BIT];

  prot_bank #(.PAGES(PAGES)) u_prot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_we_i  (prot_we),
    .set_mask_i(reg_wdata_i),
    .prot_o    (prot_o)
  );

  page_check #(.PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS), .ADDR_W(ADDR_W)) u_chk (
    .req_i  (bus_req_i),
    .addr_i (bus_addr_i),
    .prot_i (prot_o),
    .busy_i (busy_o),
    .allow_o(bus_allow_o),
    .block_o(block)
  );

  // boot erase: one-shot look at the option bit on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_pend_q <= 1'b1;
    else         boot_pend_q <= 1'b0;
  end

  assign start = sw_erase || rdp_drop_i || (boot_pend_q && rst_erase_opt_i);

  erase_seq #(.WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .busy_o     (busy_o),
    .done_o     (done),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  // software erase bit: requests during a sweep are absorbed by it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  erase_q <= 1'b0;
    else if (done)                erase_q <= 1'b0;
    else if (sw_erase && !busy_o) erase_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    viol_q <= 1'b0;
    else if (block) viol_q <= 1'b1;
    else if (vclr)  viol_q <= 1'b0;
  end

  assign erase_o = erase_q;
  assign viol_o  = viol_q;

  AST_NO_ALLOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !bus_allow_o); // R8
  AST_ALLOW_UNPROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_allow_o |-> !prot_o[bus_addr_i[ADDR_W-1:OFF_W]]); // R3
  AST_VIOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_allow_o && !busy_o) |=> viol_o); // R4
  AST_SW_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_erase && !busy_o) |=> (busy_o && erase_o)); // R5
  AST_ERASE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !erase_o); // R7
  AST_BUSY_VIOL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !viol_o) |=> !viol_o); // R8
endmodule

// File: tb/ram_guard_test.sv
module ram_guard_test;
  localparam int PG = 4, PW = 4, NW = PG * PW, AW = 4, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          reg_we = 0, reg_sel = 0, bus_req = 0, opt = 0, rdp = 0;
  logic [PG-1:0] reg_wdata = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          allow, viol, erase, busy, mem_we;
  logic [PG-1:0] prot;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  ram_guard #(.PAGES(PG), .PAGE_WORDS(PW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .bus_req_i(bus_req), .bus_addr_i(bus_addr),
    .rst_erase_opt_i(opt), .rdp_drop_i(rdp), .bus_allow_o(allow), .viol_o(viol),
    .prot_o(prot), .erase_o(erase), .busy_o(busy), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  int n_chk = 0, n_fail = 0;
  int wr_total = 0, mon_bad = 0, last_addr = 0, exp_a = 0;

  always @(negedge clk) begin
    if (!rst_n) exp_a = 0;
    else if (mem_we) begin
      if (int'(mem_addr) != exp_a || mem_wdata != '0) mon_bad++;
      last_addr = int'(mem_addr);
      exp_a++;
      wr_total++;
    end else exp_a = 0;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic reg_write(input logic sel, input logic [PG-1:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    step();
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic probe_all(input logic [PG-1:0] m);
    for (int a = 0; a < NW; a++) begin
      int blocked;
      blocked = int'(m[a / PW]);
      bus_addr = AW'(a); bus_req = 1; #1;
      chk($sformatf("R3 allow addr %0d", a), int'(allow), 1 - blocked);
      step();
      bus_req = 0;
      chk($sformatf("R4 viol addr %0d", a), int'(viol), blocked);
      if (blocked == 1) begin
        reg_write(1'b1, PG'(2));
        chk("R4 viol clear", int'(viol), 0);
      end
    end
  endtask

  // counts sweep cycles from the current (busy) cycle onward
  task automatic count_sweep(output int n, output int ebad, output int abad,
                             input int pulse_at);
    n = 0; ebad = 0; abad = 0;
    while (busy && n < 100) begin
      if (allow) abad++;
      if (erase) ebad++;
      rdp = (n == pulse_at);
      n++;
      step();
    end
    rdp = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog (R1..R10) actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int n, ebad, abad, w0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R1 prot", int'(prot), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 erase", int'(erase), 0);
    chk("R1 viol", int'(viol), 0);
    chk("R1 mem_we", int'(mem_we), 0);
    step();
    chk("R9 no boot sweep when option low", int'(busy), 0);

    probe_all('0);

    reg_write(1'b0, 4'b0101);
    chk("R2 set", int'(prot), 5);
    reg_write(1'b0, 4'b0000);
    chk("R2 zero keeps", int'(prot), 5);
    probe_all(4'b0101);
    reg_write(1'b0, 4'b1000);
    chk("R2 or-in", int'(prot), 13);
    probe_all(4'b1101);

    // software erase with a protected-page request held throughout
    w0 = wr_total; b0 = mon_bad;
    reg_write(1'b1, PG'(1));
    chk("R5 busy after write", int'(busy), 1);
    chk("R5 erase bit set", int'(erase), 1);
    bus_addr = '0; bus_req = 1; #1;
    n = 0; abad = 0; ebad = 0;
    while (busy && n < 100) begin
      if (allow) abad++;
      if (!erase) ebad++;
      n++;
      step();
    end
    bus_req = 0;
    chk("R7 busy cycles", n, NW);
    chk("R7 erase bit held", ebad, 0);
    chk("R7 erase bit cleared", int'(erase), 0);
    chk("R6 write count", wr_total - w0, NW);
    chk("R6 address order and zero data", mon_bad - b0, 0);
    chk("R6 last address", last_addr, NW - 1);
    chk("R6 protect bits kept", int'(prot), 13);
    chk("R8 no allow during sweep", abad, 0);
    chk("R8 no violation during sweep", int'(viol), 0);

    // readout downgrade, second strobe mid-sweep
    w0 = wr_total; b0 = mon_bad;
    rdp = 1; step(); rdp = 0;
    chk("R10 strobe starts sweep", int'(busy), 1);
    count_sweep(n, ebad, abad, 5);
    chk("R10 sweep not extended", n, NW);
    chk("R10 write count", wr_total - w0, NW);
    chk("R10 address order", mon_bad - b0, 0);
    chk("R10 erase bit untouched", ebad, 0);

    // reset with erase option
    rst_n = 0; opt = 1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 protect cleared by reset", int'(prot), 0);
    rst_n = 1;
    w0 = wr_total; b0 = mon_bad;
    step();
    chk("R9 boot sweep started", int'(busy), 1);
    count_sweep(n, ebad, abad, -1);
    opt = 0;
    chk("R9 boot sweep length", n, NW);
    chk("R9 boot writes", wr_total - w0, NW);
    chk("R9 boot address order", mon_bad - b0, 0);
    chk("R9 erase bit stays low", ebad, 0);
    step();
    chk("R9 single boot sweep", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule